// File: doc/BRIEF.md
# RTC Status Register with Write-Enable Latches

This block is the volatile status byte of a real-time clock device. It gathers a backup-supply indication, two sticky alarm flags, two write-permission latches and a clock-fail flag into one readable byte. A bus front end gives it byte write strobes and marks the start and the end of each status read. The alarm comparators give it one-cycle match pulses. A supply monitor gives it the present supply state.

The two latches gate all writes elsewhere in the device. The memory array may be written only while the write-enable latch is set. The clock and control registers need the register-write-enable latch as well. The latches move only on exact byte patterns. The register-write-enable latch drops by itself after each completed control-register write. The clock-fail flag is set at power-up and is cleared by the first permitted write to the time registers.

Top module: `rtcs_top`

## Requirements
- R1: `rd_data` shows, from bit 7 down to bit 0: backup flag, alarm-1 flag, alarm-0 flag, zero, zero, register-write-enable latch, write-enable latch, clock-fail flag. `alarm_hit[1]` drives bit 6 and `alarm_hit[0]` drives bit 5.
- R2: In the cycle after `rst` is sampled high, `rd_data` is 0x01 and both permission outputs are low.
- R3: Bits 4 and 3 of `rd_data` are always zero.
- R4: An `alarm_hit` pulse sets its flag one cycle later. The flag stays set until a status read ends, and a write never clears it.
- R5: When `rd_done` is sampled, the only flags that clear are those that were set in the register during the cycle `rd_start` was sampled. A hit in the `rd_start` cycle, during the read, or in the `rd_done` cycle leaves its flag set. If `rd_start` and `rd_done` arrive together, every flag set at that moment clears.
- R6: A status write of 0x02 sets the write-enable latch. A write of 0x06 sets the register-write-enable latch, but only while the write-enable latch is already set. A write of 0x00 clears both latches. Every other byte changes neither latch. No write changes bits 7, 5, 4, 3 or 0.
- R7: `arr_wr_ok` equals the write-enable latch. `ctl_wr_ok` is high only when both latches are set.
- R8: A `time_wr` pulse clears the clock-fail flag, but only while `ctl_wr_ok` is high. Without that permission the flag is unchanged. Only reset sets the flag again.
- R9: A `ctl_wr_done` pulse clears the register-write-enable latch one cycle later and leaves the write-enable latch set. It wins over a 0x06 write in the same cycle.
- R10: Bit 7 follows `on_backup` one cycle later and cannot be written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, acting as power-up |
| wr_stb | input | 1 | Status byte write strobe |
| wr_data | input | 8 | Byte being written to the status register |
| rd_start | input | 1 | First cycle of a status read |
| rd_done | input | 1 | Final cycle of a status read |
| alarm_hit | input | 2 | Alarm match pulses (bit 1 = alarm 1, bit 0 = alarm 0) |
| on_backup | input | 1 | High while the device runs from the backup supply |
| time_wr | input | 1 | A byte is being written to the time registers |
| ctl_wr_done | input | 1 | A control-register write has completed |
| rd_data | output | 8 | Current status byte |
| arr_wr_ok | output | 1 | Memory array writes permitted |
| ctl_wr_ok | output | 1 | Control and time register writes permitted |

## Verification
Every result of this block comes from a single register stage. A write, an alarm hit, a read boundary, a time write, a completion pulse or a change of supply shows at the outputs right after the next rising edge. The bench drives each stimulus just after a falling edge and holds it across exactly one rising edge. It then samples at the following falling edge, so every check looks at the cycle in which the result has just become due. The write sweep tries all 256 bytes from each of the three latch states. The read sweep tries every mix of flags set before the read, hits at the start, hits during the read and hits at the end, which pins down which flags the read clears.

// File: rtl/rtcs_pkg.sv
`timescale 1ns/1ps
package rtcs_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned NUM_ALM = 2;
    localparam int unsigned RSV_W   = BYTE_W - NUM_ALM - 4;

    localparam logic [BYTE_W-1:0] CODE_LOCK    = 8'h00;
    localparam logic [BYTE_W-1:0] CODE_ARM     = 8'h02;
    localparam logic [BYTE_W-1:0] CODE_ARM_REG = 8'h06;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_LOCK,
        CMD_ARM,
        CMD_ARM_REG
    } wcmd_e;

    typedef struct packed {
        logic wel;
        logic rwel;
    } latch_t;

    typedef struct packed {
        logic               bak;
        logic [NUM_ALM-1:0] alm;
        logic [RSV_W-1:0]   rsvd;
        logic               rwel;
        logic               wel;
        logic               fail;
    } stat_t;

    function automatic wcmd_e decode_wr(input logic [BYTE_W-1:0] b);
        wcmd_e c;
        if (b == CODE_LOCK)         c = CMD_LOCK;
        else if (b == CODE_ARM)     c = CMD_ARM;
        else if (b == CODE_ARM_REG) c = CMD_ARM_REG;
        else                        c = CMD_NONE;
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_stat(input stat_t s);
        stat_t t;
        t      = s;
        t.rsvd = '0;
        return t;
    endfunction

endpackage

// File: rtl/rtcs_alarm_bit.sv
`timescale 1ns/1ps
module rtcs_alarm_bit (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic rd_start,
    input  logic rd_done,
    output logic flag
);
    logic flag_q;
    logic snap_q;
    logic clr_mask;

    // A read that starts and ends in one cycle uses the live value.
    assign clr_mask = rd_start ? flag_q : snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            snap_q <= 1'b0;
        end else if (rd_done) begin
            flag_q <= (flag_q & ~clr_mask) | hit;
            snap_q <= 1'b0;
        end else begin
            flag_q <= flag_q | hit;
            if (rd_start) snap_q <= flag_q;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/rtcs_wr_latch.sv
`timescale 1ns/1ps
module rtcs_wr_latch
    import rtcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ctl_wr_done,
    output latch_t            lat
);
    wcmd_e  cmd;
    latch_t lat_q;
    latch_t lat_d;

    assign cmd = wr_stb ? decode_wr(wr_data) : CMD_NONE;

    always_comb begin
        lat_d = lat_q;
        case (cmd)
            CMD_LOCK: begin
                lat_d.wel  = 1'b0;
                lat_d.rwel = 1'b0;
            end
            CMD_ARM:     lat_d.wel = 1'b1;
            CMD_ARM_REG: if (lat_q.wel) lat_d.rwel = 1'b1;
            default:     ;
        endcase
        if (ctl_wr_done) lat_d.rwel = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) lat_q <= '0;
        else     lat_q <= lat_d;
    end

    assign lat = lat_q;
endmodule

// File: rtl/rtcs_fail_flag.sv
`timescale 1ns/1ps
module rtcs_fail_flag (
    input  logic clk,
    input  logic rst,
    input  logic time_wr,
    input  logic permit,
    output logic fail
);
    logic fail_q;

    always_ff @(posedge clk) begin
        if (rst)                    fail_q <= 1'b1;
        else if (time_wr && permit) fail_q <= 1'b0;
    end

    assign fail = fail_q;
endmodule

// File: rtl/rtcs_top.sv
`timescale 1ns/1ps
module rtcs_top
    import rtcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_stb,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic               rd_start,
    input  logic               rd_done,
    input  logic [NUM_ALM-1:0] alarm_hit,
    input  logic               on_backup,
    input  logic               time_wr,
    input  logic               ctl_wr_done,
    output logic [BYTE_W-1:0]  rd_data,
    output logic               arr_wr_ok,
    output logic               ctl_wr_ok
);
    logic               bak_q;
    logic [NUM_ALM-1:0] alm_flags;
    logic               fail_flag;
    latch_t             lat;
    stat_t              stat;

    always_ff @(posedge clk) begin
        if (rst) bak_q <= 1'b0;
        else     bak_q <= on_backup;
    end

    for (genvar i = 0; i < NUM_ALM; i++) begin : g_alm
        rtcs_alarm_bit u_alm (
            .clk      (clk),
            .rst      (rst),
            .hit      (alarm_hit[i]),
            .rd_start (rd_start),
            .rd_done  (rd_done),
            .flag     (alm_flags[i])
        );
    end

    rtcs_wr_latch u_lat (
        .clk         (clk),
        .rst         (rst),
        .wr_stb      (wr_stb),
        .wr_data     (wr_data),
        .ctl_wr_done (ctl_wr_done),
        .lat         (lat)
    );

    rtcs_fail_flag u_fail (
        .clk     (clk),
        .rst     (rst),
        .time_wr (time_wr),
        .permit  (ctl_wr_ok),
        .fail    (fail_flag)
    );

    always_comb begin
        stat      = '0;
        stat.bak  = bak_q;
        stat.alm  = alm_flags;
        stat.rwel = lat.rwel;
        stat.wel  = lat.wel;
        stat.fail = fail_flag;
    end

    assign rd_data   = pack_stat(stat);
    assign arr_wr_ok = lat.wel;
    assign ctl_wr_ok = lat.wel & lat.rwel;
endmodule

// File: rtl/rtcs_checks.sv
`timescale 1ns/1ps
module rtcs_checks (
    input logic       clk,
    input logic       rst,
    input logic       wr_stb,
    input logic [7:0] wr_data,
    input logic [1:0] alarm_hit,
    input logic       on_backup,
    input logic       ctl_wr_done,
    input logic [7:0] rd_data,
    input logic       arr_wr_ok,
    input logic       ctl_wr_ok
);
    AST_RESET_VALUE: assert property (@(posedge clk)
        rst |=> (rd_data == 8'h01 && !arr_wr_ok && !ctl_wr_ok)); // R2

    AST_ZERO_BITS: assert property (@(posedge clk) disable iff (rst)
        rd_data[4:3] == 2'b00); // R3

    AST_ALARM1_SET: assert property (@(posedge clk) disable iff (rst)
        alarm_hit[1] |=> rd_data[6]); // R4

    AST_ALARM0_SET: assert property (@(posedge clk) disable iff (rst)
        alarm_hit[0] |=> rd_data[5]); // R4

    AST_ODD_BYTE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_data != 8'h00 && wr_data != 8'h02 && wr_data != 8'h06 && !ctl_wr_done)
        |=> $stable(rd_data[2:1])); // R6

    AST_CTL_NEEDS_ARR: assert property (@(posedge clk) disable iff (rst)
        ctl_wr_ok |-> arr_wr_ok); // R7

    AST_FAIL_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
        !rd_data[0] |=> !rd_data[0]); // R8

    AST_REG_LATCH_DROP: assert property (@(posedge clk) disable iff (rst)
        ctl_wr_done |=> !ctl_wr_ok); // R9

    AST_BACKUP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        on_backup |=> rd_data[7]); // R10
endmodule

bind rtcs_top rtcs_checks u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_stb      (wr_stb),
    .wr_data     (wr_data),
    .alarm_hit   (alarm_hit),
    .on_backup   (on_backup),
    .ctl_wr_done (ctl_wr_done),
    .rd_data     (rd_data),
    .arr_wr_ok   (arr_wr_ok),
    .ctl_wr_ok   (ctl_wr_ok)
);

// File: tb/sim_rtcs_top.sv
`timescale 1ns/1ps
module sim_rtcs_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_start = 1'b0;
    logic       rd_done = 1'b0;
    logic [1:0] alarm_hit = 2'b00;
    logic       on_backup = 1'b0;
    logic       time_wr = 1'b0;
    logic       ctl_wr_done = 1'b0;
    logic [7:0] rd_data;
    logic       arr_wr_ok;
    logic       ctl_wr_ok;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rtcs_top u0 (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_start(rd_start), .rd_done(rd_done), .alarm_hit(alarm_hit),
        .on_backup(on_backup), .time_wr(time_wr), .ctl_wr_done(ctl_wr_done),
        .rd_data(rd_data), .arr_wr_ok(arr_wr_ok), .ctl_wr_ok(ctl_wr_ok)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] obs();
        return {ctl_wr_ok, arr_wr_ok, rd_data};
    endfunction

    task automatic wr_byte(input logic [7:0] b);
        wr_stb = 1'b1; wr_data = b;
        tick();
        wr_stb = 1'b0; wr_data = 8'h00;
    endtask

    task automatic set_state(input int s);
        wr_byte(8'h00);
        if (s >= 1) wr_byte(8'h02);
        if (s == 2) wr_byte(8'h06);
    endtask

    task automatic clear_alarms();
        rd_start = 1'b1; rd_done = 1'b1;
        tick();
        rd_start = 1'b0; rd_done = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        tick();
        rst = 1'b0;
        check("R2 reset value", obs(), {2'b00, 8'h01});

        // R6 R7: every byte from each latch state
        for (int s = 0; s < 3; s++) begin
            for (int b = 0; b < 256; b++) begin
                logic ow, orw, ew, erw;
                set_state(s);
                ow = (s >= 1); orw = (s == 2);
                wr_byte(b[7:0]);
                ew = ow; erw = orw;
                if (b == 0)      begin ew = 1'b0; erw = 1'b0; end
                else if (b == 2) ew = 1'b1;
                else if (b == 6) erw = ow ? 1'b1 : orw;
                check("R6 R7 latch write", obs(),
                      {ew & erw, ew, 5'b00000, erw, ew, 1'b1});
            end
        end

        // R9: completion clears the register latch, and wins over 0x06
        set_state(2);
        ctl_wr_done = 1'b1; tick(); ctl_wr_done = 1'b0;
        check("R9 autoclear", obs(), {2'b01, 8'h03});
        wr_byte(8'h06);
        check("R9 rearm", obs(), {2'b11, 8'h07});
        ctl_wr_done = 1'b1; wr_stb = 1'b1; wr_data = 8'h06;
        tick();
        ctl_wr_done = 1'b0; wr_stb = 1'b0; wr_data = 8'h00;
        check("R9 beats 0x06", obs(), {2'b01, 8'h03});

        // R8: clock-fail clears only with full permission
        set_state(0);
        time_wr = 1'b1; tick(); time_wr = 1'b0;
        check("R8 no permit", obs(), {2'b00, 8'h01});
        set_state(1);
        time_wr = 1'b1; tick(); time_wr = 1'b0;
        check("R8 array permit only", obs(), {2'b01, 8'h03});
        wr_byte(8'h06);
        time_wr = 1'b1; tick(); time_wr = 1'b0;
        check("R8 cleared", obs(), {2'b11, 8'h06});
        set_state(0);
        check("R8 stays clear", obs(), {2'b00, 8'h00});

        // R10: backup flag follows the supply input, writes do not touch it
        on_backup = 1'b1; tick();
        check("R10 backup set", obs(), {2'b00, 8'h80});
        wr_byte(8'h00);
        wr_byte(8'hFF);
        check("R10 not writable", obs(), {2'b00, 8'h80});
        on_backup = 1'b0; tick();
        check("R10 backup clear", obs(), {2'b00, 8'h00});

        // R4: flags are sticky and writes do not clear them
        clear_alarms();
        alarm_hit = 2'b10; tick(); alarm_hit = 2'b00;
        check("R4 alarm1 set R1", obs(), {2'b00, 8'h40});
        wr_byte(8'h00);
        repeat (3) tick();
        check("R4 sticky", obs(), {2'b00, 8'h40});

        // R5: sweep of flag state and hit timing around a read
        for (int f = 0; f < 4; f++)
            for (int hs = 0; hs < 4; hs++)
                for (int hm = 0; hm < 4; hm++)
                    for (int hd = 0; hd < 4; hd++) begin
                        logic [1:0] exp_f;
                        clear_alarms();
                        alarm_hit = f[1:0]; tick(); alarm_hit = 2'b00;
                        check("R4 preset", {2'b00, rd_data}, {2'b00, 1'b0, f[1:0], 5'b00000});
                        rd_start = 1'b1; alarm_hit = hs[1:0]; tick();
                        rd_start = 1'b0; alarm_hit = hm[1:0]; tick();
                        alarm_hit = hd[1:0]; rd_done = 1'b1; tick();
                        rd_done = 1'b0; alarm_hit = 2'b00;
                        exp_f = ((f[1:0] | hs[1:0] | hm[1:0]) & ~f[1:0]) | hd[1:0];
                        check("R5 read clear", {8'h00, rd_data[6:5]}, {8'h00, exp_f});
                    end

        // R5: start and end in one cycle clears live flags
        clear_alarms();
        alarm_hit = 2'b11; tick(); alarm_hit = 2'b00;
        clear_alarms();
        check("R5 single cycle read", obs(), {2'b00, 8'h00});

        // R2: reset from a busy state
        wr_byte(8'h02); wr_byte(8'h06);
        alarm_hit = 2'b01; on_backup = 1'b1; tick();
        alarm_hit = 2'b00; on_backup = 1'b0;
        rst = 1'b1; tick(); rst = 1'b0;
        check("R2 reset again R3", obs(), {2'b00, 8'h01});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule